// File: doc/BRIEF.md
# Sized Arithmetic Flag Unit with Condition Register

This block is the flag side of a CPU datapath for byte, word and longword operands. Each cycle it takes two operands, a size code and an operation code. It presents the sized result at once, together with a write-enable for that result. On the next clock edge it updates an 8-bit condition register. The supported operations are add, add-with-carry, subtract, subtract-with-carry, compare, negate, one-bit shifts and rotates, and whole-register load, AND, OR and XOR.

The half-carry position follows the operand size: a carry or borrow out of bit 3 for bytes, bit 11 for words and bit 27 for longwords. The carry bit holds the carry on addition, the borrow on subtraction, and the bit that leaves the operand on a shift or rotate. Only the mask bit has a defined value after reset. Software must load the rest of the register before it relies on it.

Condition register layout: bit 7 = I (mask), bit 6 = spare, bit 5 = H, bit 4 = U, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.

Top module: `sized_flag_alu`

## Requirements
- R1: While `rst_n` is low, the condition register's bit 7 (I) is forced to 1. All other bits are left undefined.
- R2: Op 1 (add) gives a+b and op 2 (add-with-carry) gives a+b+C. C is set to the carry out of the sized top bit. Size codes: 0 = byte, 1 = word, 2 or 3 = longword.
- R3: Op 3 (subtract) gives a-b, op 4 (subtract-with-carry) gives a-b-C, and op 6 (negate) gives 0-a. C is set to the borrow out of the sized top bit.
- R4: Op 5 (compare) updates flags exactly as subtract does, and keeps `res_we` low.
- R5: For ops 1, 3, 5 and 6 at every size, and for ops 2 and 4 at byte size, H (bit 5) is set to the carry or borrow out of bit 3 (byte), bit 11 (word) or bit 27 (longword).
- R6: Ops 2 and 4 at word or longword size leave H unchanged.
- R7: `result` holds the operation's value in the low 8, 16 or 32 bits and zeros above the size. N (bit 3) is the sized top bit of the result. Z (bit 2) is 1 when the sized result is zero.
- R8: V (bit 1) is set for signed overflow. For add this means the operands have the same sign and the result sign differs. For subtract, compare and negate it means the operand signs differ and the result sign differs from the minuend.
- R9: Ops 7, 8, 9 and 10 (shift left, logical shift right, rotate left, rotate right, each by one bit within the size) set C to the bit shifted out, clear V, update N and Z, and leave H unchanged.
- R10: Op 11 loads the register from `src_b[7:0]`. Ops 12, 13 and 14 AND, OR and XOR the register with `src_b[7:0]`. All eight bits take part, including I and U.
- R11: Arithmetic and shift ops never change bits 7, 6 and 4.
- R12: Op 0 and op 15 leave the whole register unchanged and keep `res_we` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op | input | 4 | Operation code |
| size | input | 2 | Operand size code |
| src_a | input | 32 | First operand (minuend; the negate and shift source) |
| src_b | input | 32 | Second operand, or immediate in bits 7:0 for register ops |
| result | output | 32 | Sized result, zero-extended |
| res_we | output | 1 | Result is to be written back |
| ccr | output | 8 | Condition register |

## Verification
The in-module assertions check four things on every cycle: that I, the spare bit and U are held outside register ops, that H holds on wide carry-chained ops, that shifts clear V, and that no-ops freeze the register. They also check the exact load value, zero-extension of byte results and that compare never writes. The half-carry position for each size, borrow polarity, overflow corners and shifted-out bits depend on particular operand values. Only the bench's vector table, with hand-computed results and flags, can show those.

// File: rtl/sized_flag_alu.sv
module sized_flag_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic [31:0] result,
  output logic        res_we,
  output logic [7:0]  ccr
);
  localparam logic [3:0] OP_ADD  = 4'd1,  OP_ADDX = 4'd2,  OP_SUB  = 4'd3;
  localparam logic [3:0] OP_SUBX = 4'd4,  OP_CMP  = 4'd5,  OP_NEG  = 4'd6;
  localparam logic [3:0] OP_SHL  = 4'd7,  OP_SHR  = 4'd8,  OP_ROL  = 4'd9;
  localparam logic [3:0] OP_ROR  = 4'd10, OP_LDC  = 4'd11, OP_ANDC = 4'd12;
  localparam logic [3:0] OP_ORC  = 4'd13, OP_XORC = 4'd14;

  logic [7:0] ccr_q, ccr_d;

  wire is_arith = (op >= OP_ADD) && (op <= OP_NEG);
  wire is_sub   = (op == OP_SUB) || (op == OP_SUBX) || (op == OP_CMP) || (op == OP_NEG);
  wire is_shift = (op >= OP_SHL) && (op <= OP_ROR);
  wire is_reg   = (op >= OP_LDC) && (op <= OP_XORC);
  wire chained  = (op == OP_ADDX) || (op == OP_SUBX);

  logic [31:0] mask;
  always_comb
    case (size)
      2'd0:    mask = 32'h0000_00FF;
      2'd1:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  wire [31:0] top_bit = mask ^ (mask >> 1);

  wire [31:0] x_op  = (op == OP_NEG) ? 32'd0 : src_a;
  wire [31:0] y_op  = (op == OP_NEG) ? src_a : src_b;
  wire [31:0] y_eff = is_sub ? ~y_op : y_op;

  logic cin;
  always_comb
    case (op)
      OP_ADD:  cin = 1'b0;
      OP_ADDX: cin = ccr_q[0];
      OP_SUBX: cin = ~ccr_q[0];
      default: cin = 1'b1;
    endcase

  wire [32:0] sum = {1'b0, x_op} + {1'b0, y_eff} + {32'd0, cin};
  wire [32:0] cv  = {1'b0, x_op} ^ {1'b0, y_eff} ^ sum;

  logic c_out, c_top, c_half;
  always_comb
    case (size)
      2'd0:    {c_out, c_top, c_half} = {cv[8],  cv[7],  cv[4]};
      2'd1:    {c_out, c_top, c_half} = {cv[16], cv[15], cv[12]};
      default: {c_out, c_top, c_half} = {cv[32], cv[31], cv[28]};
    endcase

  wire [31:0] a_m   = src_a & mask;
  wire        a_top = |(src_a & top_bit);
  logic [31:0] sh_res;
  logic        sh_c;
  always_comb begin
    sh_res = a_m << 1;
    sh_c   = a_top;
    case (op)
      OP_SHR:  begin sh_res = a_m >> 1; sh_c = src_a[0]; end
      OP_ROL:  sh_res = (a_m << 1) | {31'd0, a_top};
      OP_ROR:  begin sh_res = (a_m >> 1) | (src_a[0] ? top_bit : 32'd0); sh_c = src_a[0]; end
      default: ;
    endcase
  end

  assign result = (is_shift ? sh_res : sum[31:0]) & mask;
  assign res_we = (is_arith && op != OP_CMP) || is_shift;
  wire neg_f  = |(result & top_bit);
  wire zero_f = ~|result;

  always_comb begin
    ccr_d = ccr_q;
    if (is_arith) begin
      if (size == 2'd0 || !chained) ccr_d[5] = c_half ^ is_sub;
      ccr_d[3:0] = {neg_f, zero_f, c_out ^ c_top, c_out ^ is_sub};
    end else if (is_shift) begin
      ccr_d[3:0] = {neg_f, zero_f, 1'b0, sh_c};
    end else begin
      case (op)
        OP_LDC:  ccr_d = src_b[7:0];
        OP_ANDC: ccr_d = ccr_q & src_b[7:0];
        OP_ORC:  ccr_d = ccr_q | src_b[7:0];
        OP_XORC: ccr_d = ccr_q ^ src_b[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ccr_q <= {1'b1, 7'bxxxxxxx};
    else        ccr_q <= ccr_d;

  assign ccr = ccr_q;

  assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ccr_q[7]);
  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> !res_we);
  assert_wide_chain_h_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && size != 2'd0) |=> ccr_q[5] == $past(ccr_q[5]));
  assert_shift_clears_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |=> !ccr_q[1]);
  assert_load_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LDC) |=> ccr_q == $past(src_b[7:0]));
  assert_keep_mask_user_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_arith || is_shift) |=> (ccr_q[7:6] == $past(ccr_q[7:6])) && (ccr_q[4] == $past(ccr_q[4])));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_arith || is_shift || is_reg) |=> $stable(ccr_q));
  always_comb
    if (size == 2'd0) assert_byte_zero_ext_R7: assert (result[31:8] == 24'd0);
endmodule

// File: tb/sized_flag_alu_test.sv
module sized_flag_alu_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [1:0] size = 2'd0;
  logic [31:0] src_a = 32'd0, src_b = 32'd0;
  logic [31:0] result;
  logic res_we;
  logic [7:0] ccr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sized_flag_alu uut (.clk(clk), .rst_n(rst_n), .op(op), .size(size), .src_a(src_a),
                      .src_b(src_b), .result(result), .res_we(res_we), .ccr(ccr));

  typedef struct packed {
    logic [3:0] rq; logic [3:0] op; logic [1:0] sz; logic [31:0] a; logic [31:0] b;
    logic [7:0] pre; logic we; logic [31:0] res; logic [7:0] cc;
  } vec_t;
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{2,  1, 0, 32'hABCD120F, 32'h1, 8'h00, 1, 32'h10, 8'h20},        // R2 R7 half-carry byte
    '{8,  1, 0, 32'h7F, 32'h1, 8'h00, 1, 32'h80, 8'h2A},              // R8 add overflow
    '{2,  1, 0, 32'hFF, 32'h1, 8'h00, 1, 32'h00, 8'h25},              // R2 carry out, Z
    '{5,  1, 1, 32'h0800, 32'h0800, 8'h00, 1, 32'h1000, 8'h20},       // R5 word bit 11
    '{5,  1, 1, 32'h000F, 32'h0001, 8'h00, 1, 32'h0010, 8'h00},       // R5 word ignores bit 3
    '{5,  1, 2, 32'h08000000, 32'h08000000, 8'h00, 1, 32'h10000000, 8'h20}, // R5 long bit 27
    '{8,  1, 2, 32'h80000000, 32'h80000000, 8'h00, 1, 32'h0, 8'h07},  // R8 long overflow
    '{2,  2, 0, 32'h10, 32'h20, 8'h11, 1, 32'h31, 8'h10},             // R2 add-with-carry
    '{3,  3, 0, 32'h10, 32'h01, 8'h00, 1, 32'h0F, 8'h20},             // R3 half borrow
    '{3,  3, 0, 32'h00, 32'h01, 8'h00, 1, 32'hFF, 8'h29},             // R3 borrow
    '{8,  3, 0, 32'h80, 32'h01, 8'h00, 1, 32'h7F, 8'h22},             // R8 sub overflow
    '{3,  4, 0, 32'h05, 32'h05, 8'h01, 1, 32'hFF, 8'h29},             // R3 sub-with-carry
    '{4,  5, 1, 32'h1234, 32'h1234, 8'h00, 0, 32'h0, 8'h04},          // R4 compare
    '{3,  6, 0, 32'h01, 32'h0, 8'h00, 1, 32'hFF, 8'h29},              // R3 negate
    '{8,  6, 0, 32'h80, 32'h0, 8'h00, 1, 32'h80, 8'h0B},              // R8 negate min
    '{3,  6, 2, 32'h0, 32'h0, 8'h00, 1, 32'h0, 8'h04},                // R3 negate zero
    '{5,  3, 2, 32'h10000000, 32'h1, 8'h00, 1, 32'h0FFFFFFF, 8'h20},  // R5 long borrow 27
    '{6,  2, 1, 32'h0800, 32'h0800, 8'h00, 1, 32'h1000, 8'h00},       // R6 H held 0
    '{6,  2, 1, 32'h0001, 32'h0001, 8'h20, 1, 32'h0002, 8'h20},       // R6 H held 1
    '{6,  4, 2, 32'h10000000, 32'h1, 8'h00, 1, 32'h0FFFFFFF, 8'h00},  // R6 long subx
    '{9,  7, 0, 32'h81, 32'h0, 8'h22, 1, 32'h02, 8'h21},              // R9 shl byte
    '{9,  8, 1, 32'h8001, 32'h0, 8'h00, 1, 32'h4000, 8'h01},          // R9 shr word
    '{9,  9, 2, 32'h80000000, 32'h0, 8'h00, 1, 32'h1, 8'h01},         // R9 rol long
    '{9, 10, 0, 32'h01, 32'h0, 8'h00, 1, 32'h80, 8'h09},              // R9 ror byte
    '{9,  7, 1, 32'h8000, 32'h0, 8'h00, 1, 32'h0, 8'h05},             // R9 shl to zero
    '{10, 11, 0, 32'h0, 32'hA5, 8'h3C, 0, 32'h0, 8'hA5},              // R10 load
    '{10, 12, 0, 32'h0, 32'h0F, 8'hFF, 0, 32'h0, 8'h0F},              // R10 and
    '{10, 13, 0, 32'h0, 32'h90, 8'h00, 0, 32'h0, 8'h90},              // R10 or
    '{10, 14, 0, 32'h0, 32'hFF, 8'h5A, 0, 32'h0, 8'hA5},              // R10 xor
    '{12, 0, 0, 32'h12, 32'h34, 8'h3C, 0, 32'h0, 8'h3C},              // R12 nop
    '{12, 15, 2, 32'h12, 32'h34, 8'h3C, 0, 32'h0, 8'h3C},             // R12 unused code
    '{11, 1, 0, 32'h01, 32'h01, 8'hD0, 1, 32'h02, 8'hD0},             // R11 I/spare/U kept
    '{7,  3, 1, 32'hFFFF8000, 32'h1, 8'h00, 1, 32'h00007FFF, 8'h22}   // R7 word zero-extend
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] b);
    op = o; size = s; src_a = a; src_b = b;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mask set in reset", {31'd0, ccr[7]}, 32'd1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(4'd11, 2'd0, 32'd0, {24'd0, VEC[i].pre});
      @(negedge clk);
      apply(VEC[i].op, VEC[i].sz, VEC[i].a, VEC[i].b);
      #1;
      check($sformatf("R%0d vec %0d res_we", VEC[i].rq, i), {31'd0, res_we}, {31'd0, VEC[i].we});
      if (VEC[i].we)
        check($sformatf("R%0d vec %0d result", VEC[i].rq, i), result, VEC[i].res);
      @(negedge clk);
      check($sformatf("R%0d vec %0d ccr", VEC[i].rq, i), {24'd0, ccr}, {24'd0, VEC[i].cc});
    end
    // R12: register held over several idle cycles
    apply(4'd11, 2'd0, 32'd0, 32'h6B);
    @(negedge clk);
    apply(4'd0, 2'd1, 32'hFFFF, 32'hFFFF);
    repeat (4) @(negedge clk);
    check("R12 idle hold", {24'd0, ccr}, 32'h6B);
    // R1: reset mid-run re-forces I
    apply(4'd11, 2'd0, 32'd0, 32'h00);
    @(negedge clk);
    check("R1 mask cleared by load", {31'd0, ccr[7]}, 32'd0);
    apply(4'd0, 2'd0, 32'd0, 32'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mask set by reset", {31'd0, ccr[7]}, 32'd1);
    rst_n = 1'b1;
    // R2: add-with-carry chain, carry from one byte into the next
    apply(4'd11, 2'd0, 32'd0, 32'h00);
    @(negedge clk);
    apply(4'd1, 2'd0, 32'hF0, 32'h20);
    @(negedge clk);
    check("R2 chain low carry", {31'd0, ccr[0]}, 32'd1);
    apply(4'd2, 2'd0, 32'h01, 32'h02);
    #1;
    check("R2 chain high sum", result, 32'h04);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule